// File: doc/BRIEF.md
# Two-Stage Supply Brownout Monitor

This block watches a digitized supply-voltage code and reacts at two levels. When the code falls below an upper threshold it raises a warning. The warning is a level status that software can poll, and it also sets a sticky interrupt-pending bit. That bit reaches the interrupt line only while the interrupt enable is set. When the code falls further, below a lower threshold, the block asserts a chip reset. Each threshold has its own hysteresis band, so a noisy code near a boundary does not make either output chatter.

The reset is registered on the monitor clock. Once asserted, it holds for a minimum number of cycles. It stays asserted however far the code falls, and it only lets go when the external power-on reset takes over, which is signalled by `por_active`. While `por_active` is high, all state is cleared so that power-on reset alone holds the chip. All thresholds, hysteresis widths and the minimum hold are parameters given in code units or cycles.

Top module: `brownout_monitor`

## Requirements
- R1: After `rst_n` is low, `warn_status`, `irq` and `bod_rst` are all 0.
- R2: `warn_status` becomes 1 at the first clock edge that samples `vcode < WARN_THR`. A code equal to `WARN_THR` does not set it.
- R3: Once set, `warn_status` stays 1 for every code up to and including `WARN_THR+WARN_HYST`. It clears at the first edge that samples a code above that value.
- R4: A 0-to-1 change of the warning sets a pending bit, whether or not interrupts are enabled. `irq` is 1 exactly when that bit is set and `irq_en` is 1.
- R5: A high `irq_clr` at a clock edge clears the pending bit. If a new warning rise happens at the same edge, the rise wins and the bit stays set.
- R6: `bod_rst` becomes 1 at the first edge that samples `vcode < RST_THR`. A code equal to `RST_THR` does not assert it.
- R7: After the minimum hold has elapsed, `bod_rst` stays 1 for codes up to `RST_THR+RST_HYST`. It clears at the first edge that samples a code above that value.
- R8: Once asserted, `bod_rst` stays high for at least `MIN_RST_CYC` cycles, even if the code recovers at once. With the code already recovered, it stays high for exactly that many cycles.
- R9: `bod_rst` stays 1 for every code below `RST_THR`, down to 0, for as long as `por_active` is low.
- R10: A high `por_active` at an edge clears the warning, the pending bit and the reset. Below `RST_THR` after `por_active` falls, the reset asserts again at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst_n | input | 1 | Asynchronous active-low reset of the logic |
| vcode | input | W | Digitized supply voltage code |
| por_active | input | 1 | Power-on reset currently holding the chip |
| irq_en | input | 1 | Interrupt enable for the warning stage |
| irq_clr | input | 1 | Write-1 clear pulse for the pending warning |
| warn_status | output | 1 | Raw warning level (hysteresis applied) |
| irq | output | 1 | Warning interrupt (pending and enabled) |
| bod_rst | output | 1 | Brownout chip reset, registered |

## Verification
The bench sweeps the code across each exact boundary. A design with an off-by-one comparison would set or clear a stage one code too early, and the checks at `WARN_THR`, `RST_THR` and the top of each hysteresis band catch that. The bench also records a warning while interrupts are masked and then enables them, and it issues a clear in the same cycle as a new rise; a design that drops masked events or lets the clear win would lose an interrupt. Short reset dips and a ramp down to code 0 check that the reset is neither released before its minimum hold nor released at very low codes. A `por_active` pulse checks that the hand-over to power-on reset really drops the brownout reset.

// File: rtl/brownout_monitor.sv
module brownout_monitor #(
  parameter int W           = 10,
  parameter int WARN_THR    = 590,
  parameter int WARN_HYST   = 8,
  parameter int RST_THR     = 530,
  parameter int RST_HYST    = 8,
  parameter int MIN_RST_CYC = 16   // must be >= 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] vcode,
  input  logic         por_active,
  input  logic         irq_en,
  input  logic         irq_clr,
  output logic         warn_status,
  output logic         irq,
  output logic         bod_rst
);
  localparam logic [W:0] WARN_SET = (W+1)'(WARN_THR);
  localparam logic [W:0] WARN_CLR = (W+1)'(WARN_THR + WARN_HYST);
  localparam logic [W:0] RST_SET  = (W+1)'(RST_THR);
  localparam logic [W:0] RST_CLR  = (W+1)'(RST_THR + RST_HYST);
  localparam int         CW       = $clog2(MIN_RST_CYC + 1);
  localparam logic [CW-1:0] CNT_MIN = CW'(MIN_RST_CYC);

  logic [W:0]    vx;
  logic          warn_q, pend_q, rlvl_q, rst_q;
  logic [CW-1:0] cnt_q;
  logic          warn_d, rlvl_d, warn_rise;

  assign vx        = {1'b0, vcode};
  assign warn_d    = (vx < WARN_SET) | (warn_q & ~(vx > WARN_CLR));
  assign rlvl_d    = (vx < RST_SET)  | (rlvl_q & ~(vx > RST_CLR));
  assign warn_rise = warn_d & ~warn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warn_q <= 1'b0;
      pend_q <= 1'b0;
      rlvl_q <= 1'b0;
      rst_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (por_active) begin
      warn_q <= 1'b0;
      pend_q <= 1'b0;
      rlvl_q <= 1'b0;
      rst_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      warn_q <= warn_d;
      pend_q <= warn_rise | (pend_q & ~irq_clr);
      rlvl_q <= rlvl_d;
      if (!rst_q) begin
        if (rlvl_d) begin
          rst_q <= 1'b1;
          cnt_q <= CW'(1);
        end
      end else if (cnt_q < CNT_MIN) begin
        cnt_q <= cnt_q + CW'(1);
      end else if (!rlvl_d) begin
        rst_q <= 1'b0;
      end
    end
  end

  assign warn_status = warn_q;
  assign irq         = pend_q & irq_en;
  assign bod_rst     = rst_q;

  // Independent run-length monitor of the reset output
  logic [CW-1:0] hi_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 hi_run <= '0;
    else if (!rst_q)            hi_run <= '0;
    else if (hi_run < CNT_MIN)  hi_run <= hi_run + CW'(1);
  end

  // R8
  min_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bod_rst) && !$past(por_active) |-> hi_run >= CNT_MIN);

  // R10
  por_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(por_active) |-> !bod_rst && !warn_status && !irq);

  // R2
  warn_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warn_status) |-> {1'b0, $past(vcode)} < WARN_SET);

  // R3
  warn_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(warn_status) && !$past(por_active) |-> {1'b0, $past(vcode)} > WARN_CLR);

  // R7
  rst_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bod_rst) && !$past(por_active) |-> {1'b0, $past(vcode)} > RST_CLR);

  // R5
  pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr && !por_active && $stable(irq_en) |=> irq || !irq_en);
endmodule

// File: tb/brownout_monitor_tb_top.sv
`timescale 1ns/1ps
module brownout_monitor_tb_top;
  localparam int W = 10, WT = 590, WH = 8, RT = 530, RH = 8, MINC = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] vcode = W'(700);
  logic por_active = 1'b0, irq_en = 1'b0, irq_clr = 1'b0;
  logic warn_status, irq, bod_rst;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  brownout_monitor #(.W(W), .WARN_THR(WT), .WARN_HYST(WH), .RST_THR(RT),
                     .RST_HYST(RH), .MIN_RST_CYC(MINC)) dut_i (
    .clk(clk), .rst_n(rst_n), .vcode(vcode), .por_active(por_active),
    .irq_en(irq_en), .irq_clr(irq_clr), .warn_status(warn_status),
    .irq(irq), .bod_rst(bod_rst));

  // Behavioural reference
  int m_warn = 0, m_pend = 0, m_rlvl = 0, m_rst = 0, m_held = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || por_active) begin
      m_warn = 0; m_pend = 0; m_rlvl = 0; m_rst = 0; m_held = 0;
    end else begin
      int v, nw, nr;
      v  = int'(vcode);
      nw = (v < WT) ? 1 : ((v > WT + WH) ? 0 : m_warn);
      nr = (v < RT) ? 1 : ((v > RT + RH) ? 0 : m_rlvl);
      if (nw == 1 && m_warn == 0) m_pend = 1;
      else if (irq_clr)           m_pend = 0;
      m_warn = nw;
      m_rlvl = nr;
      if (m_rst == 0) begin
        if (nr == 1) begin m_rst = 1; m_held = 1; end
      end else begin
        if (m_held >= MINC && nr == 0) m_rst = 0;
        else if (m_held < MINC) m_held++;
      end
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      check("R2/R3 model warn_status", warn_status, m_warn[0]);
      check("R4/R5 model irq", irq, m_pend[0] & irq_en);
      check("R6-R10 model bod_rst", bod_rst, m_rst[0]);
    end
  end

  task automatic apply(input int code);
    @(negedge clk); vcode = W'(code);
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int highs;
    repeat (3) @(negedge clk);
    check("R1 warn reset", warn_status, 1'b0);
    check("R1 irq reset", irq, 1'b0);
    check("R1 bod_rst reset", bod_rst, 1'b0);
    @(negedge clk); rst_n = 1'b1; irq_en = 1'b1;
    apply(700);
    apply(WT);     check("R2 equal to threshold", warn_status, 1'b0);
    apply(WT - 1); check("R2 below threshold", warn_status, 1'b1);
    check("R4 irq on rise", irq, 1'b1);
    apply(WT + WH); check("R3 inside band holds", warn_status, 1'b1);
    apply(WT + WH + 1); check("R3 above band clears", warn_status, 1'b0);
    check("R4 pending sticky", irq, 1'b1);
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    check("R5 clear", irq, 1'b0);
    irq_en = 1'b0;
    apply(580); check("R4 masked irq", irq, 1'b0);
    check("R4 status while masked", warn_status, 1'b1);
    irq_en = 1'b1; #1;
    check("R4 pending kept while masked", irq, 1'b1);
    apply(700);
    @(negedge clk); irq_clr = 1'b1; vcode = W'(580);
    @(negedge clk); irq_clr = 1'b0;
    check("R5 rise beats clear", irq, 1'b1);
    apply(RT + 1); check("R6 above threshold", bod_rst, 1'b0);
    apply(RT);     check("R6 equal to threshold", bod_rst, 1'b0);
    apply(RT - 1); check("R6 below threshold", bod_rst, 1'b1);
    for (int c = RT - 1; c >= 0; c -= 9) begin
      apply(c); check("R9 held while falling", bod_rst, 1'b1);
    end
    apply(0); check("R9 held at code 0", bod_rst, 1'b1);
    for (int c = 0; c <= RT + RH; c += 13) apply(c);
    apply(RT + RH); check("R7 inside band holds", bod_rst, 1'b1);
    apply(RT + RH + 1); check("R7 above band clears", bod_rst, 1'b0);
    repeat (3) apply(700);
    @(negedge clk); vcode = W'(500);
    @(negedge clk); vcode = W'(700);
    highs = 0;
    for (int i = 0; i < 40; i++) begin
      if (bod_rst) highs++;
      @(negedge clk);
    end
    n_chk++;
    if (highs != MINC) begin
      n_fail++;
      $display("FAIL R8 min hold: actual %0d expected %0d", highs, MINC);
    end
    apply(500); check("R10 reset before handoff", bod_rst, 1'b1);
    @(negedge clk); por_active = 1'b1;
    @(negedge clk);
    check("R10 bod_rst dropped", bod_rst, 1'b0);
    check("R10 warn dropped", warn_status, 1'b0);
    check("R10 irq dropped", irq, 1'b0);
    por_active = 1'b0;
    @(negedge clk); check("R10 reasserts after handoff", bod_rst, 1'b1);
    repeat (MINC + 2) apply(720);
    check("R7 recovered", bod_rst, 1'b0);
    finish_run();
  end
endmodule